// File: doc/BRIEF.md
# Terminal Line Transmit Channel

This block is the sending half of one serial terminal line. Software sees two words on a 16-bit register bus: a control/status word and an 8-bit character buffer. A write to the buffer hands one character to the line. The block then waits a fixed number of clock cycles, which stands in for the time a character takes on the wire. At the end of that wait it raises a one-cycle strobe carrying the character to a downstream serializer, sets its done flag, and requests an interrupt if interrupts are enabled.

The line may be unconnected. In that case the character is dropped, but done is still set after the usual wait, so software never stalls. If the line is connected and the serializer reports it is not ready, the block waits another full period and tries again. Clear-to-send is shown in the status word. Under modem control it follows the modem input. Without modem control it is set when the line connects and cleared when the line drops.

Top module: `txc_line_tx`

## Requirements
- R1: After reset, done is 1 and the control/status word reads 0x0080. The buffer reads 0, and both irq and char_valid are 0. Any transfer in flight is cancelled.
- R2: A word write to the control/status word (reg_addr = 2'b00) stores only the bits of mask 16'o000535. The bits are 0 (request to send), 2 (maintenance), 3, 4, 6 (interrupt enable) and 8. A read returns the stored bits, with done at bit 7 and clear-to-send at bit 1, all masked by 16'o100737.
- R3: A byte write (reg_byte = 1) to the control/status word takes the byte from reg_wdata[7:0]. With reg_addr[0] = 1 the byte lands in bits 15:8, and with reg_addr[0] = 0 it lands in bits 7:0. The other half keeps its value, and the write mask of R2 still applies.
- R4: Any write to the buffer (reg_addr[1] = 1) clears done and irq on the next edge and restarts the transfer delay. Only a word write, or a byte write with reg_addr[0] = 0, loads reg_wdata[7:0]. An odd byte write leaves the buffer unchanged.
- R5: Take a connected line (line_conn = 1) whose serializer is ready (tx_ready = 1) when the delay expires. Then char_valid is high for one cycle, exactly DELAY_CYCLES clock edges after the edge that took the buffer write, with char_data equal to the buffer. Done is set on the same edge.
- R6: If the delay expires while line_conn = 1 and tx_ready = 0, nothing is emitted and done stays 0. A new full delay of DELAY_CYCLES starts.
- R7: If the delay expires while line_conn = 0, done is set DELAY_CYCLES edges after the write and char_valid stays 0.
- R8: When done is set while interrupt enable (bit 6) is 1, irq rises. Writing bit 6 to 1 while done is 1 and bit 6 was 0 raises irq on the next edge. Writing bit 6 to 0 lowers it.
- R9: With modem_en = 1, clear-to-send (status bit 1) equals modem_cts one edge later. With modem_en = 0, it is set one edge after line_conn rises and cleared one edge after line_conn is 0.
- R10: Reading the buffer returns the last loaded character in bits 7:0, with bits 15:8 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Bit 1 selects the buffer (1) or the control/status word (0); bit 0 is the odd byte |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_byte | input | 1 | Byte access when 1, word access when 0 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word, combinational |
| line_conn | input | 1 | Line connected |
| modem_en | input | 1 | Modem control mode |
| modem_cts | input | 1 | Clear-to-send from the modem logic |
| tx_ready | input | 1 | Downstream serializer ready |
| char_valid | output | 1 | One-cycle strobe of an emitted character |
| char_data | output | 8 | Emitted character |
| irq | output | 1 | Interrupt request |

## Verification
Characters are sent under three line conditions: connected and ready, connected but not ready at the first expiry, and unconnected. These show the emit path, the retry path and the silent-drop path. Each case is timed to the exact edge, so a wrong delay or a missing reload shows up as a timing error rather than a data error. An odd byte write to the buffer confirms that the transfer starts without loading the character. Word and byte writes to the control/status word check the write mask and the byte lanes. The interrupt-enable sequences check that irq rises when it should and is withdrawn when it should.

// File: rtl/txc_pkg.sv
package txc_pkg;
    localparam logic [15:0] CSR_WMASK = 16'o000535;
    localparam logic [15:0] CSR_RMASK = 16'o100737;
    localparam int DONE_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int CTS_BIT  = 1;

    typedef struct packed {
        logic [15:0] csr;
        logic        done;
        logic        irq;
        logic [7:0]  chr;
        logic        emit;
    } txc_state_t;
endpackage

// File: rtl/txc_timer.sv
module txc_timer #(
    parameter int DELAY_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(DELAY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY_CYCLES);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             run_d, run_q;

    always_comb begin
        cnt_d    = cnt_q;
        run_d    = run_q;
        expire_o = run_q && (cnt_q == ONE);
        if (start_i) begin
            cnt_d = LOAD;
            run_d = 1'b1;
        end else if (run_q) begin
            if (cnt_q == ONE) begin
                run_d = 1'b0;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    // R6
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !start_i && cnt_q != ONE) |=> (run_q && cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/txc_cts.sv
module txc_cts (
    input  logic clk,
    input  logic rst_n,
    input  logic line_conn,
    input  logic modem_en,
    input  logic modem_cts,
    output logic cts_o
);
    logic cts_d, cts_q;
    logic conn_d, conn_q;

    always_comb begin
        conn_d = line_conn;
        cts_d  = cts_q;
        if (modem_en)
            cts_d = modem_cts;
        else if (!line_conn)
            cts_d = 1'b0;
        else if (!conn_q)
            cts_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_q  <= 1'b0;
            conn_q <= 1'b0;
        end else begin
            cts_q  <= cts_d;
            conn_q <= conn_d;
        end
    end

    assign cts_o = cts_q;

    // R9
    cts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (modem_en || !line_conn) |=> (cts_q == ($past(modem_en) && $past(modem_cts))));
endmodule

// File: rtl/txc_line_tx.sv
module txc_line_tx
    import txc_pkg::*;
#(
    parameter int DELAY_CYCLES = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_byte,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        line_conn,
    input  logic        modem_en,
    input  logic        modem_cts,
    input  logic        tx_ready,
    output logic        char_valid,
    output logic [7:0]  char_data,
    output logic        irq
);
    txc_state_t s_d, s_q;
    logic        expire, restart, cts;
    logic        csr_wr, buf_wr;
    logic [15:0] merged, view;

    assign csr_wr = reg_wr && !reg_addr[1];
    assign buf_wr = reg_wr && reg_addr[1];

    txc_timer #(.DELAY_CYCLES(DELAY_CYCLES)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (buf_wr || restart),
        .expire_o (expire)
    );

    txc_cts cts_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_conn (line_conn),
        .modem_en  (modem_en),
        .modem_cts (modem_cts),
        .cts_o     (cts)
    );

    always_comb begin
        view = s_q.csr;
        view[DONE_BIT] = s_q.done;
        view[CTS_BIT]  = cts;
        view = view & CSR_RMASK;
    end

    always_comb begin
        s_d      = s_q;
        s_d.emit = 1'b0;
        restart  = 1'b0;
        if (!reg_byte)
            merged = reg_wdata;
        else if (reg_addr[0])
            merged = {reg_wdata[7:0], s_q.csr[7:0]};
        else
            merged = {s_q.csr[15:8], reg_wdata[7:0]};

        if (csr_wr) begin
            if (!merged[IE_BIT])
                s_d.irq = 1'b0;
            else if (s_q.done && !s_q.csr[IE_BIT])
                s_d.irq = 1'b1;
            s_d.csr = (s_q.csr & ~CSR_WMASK) | (merged & CSR_WMASK);
        end

        if (buf_wr) begin
            if (!reg_byte || !reg_addr[0])
                s_d.chr = reg_wdata[7:0];
            s_d.done = 1'b0;
            s_d.irq  = 1'b0;
        end else if (expire) begin
            if (line_conn && !tx_ready) begin
                restart = 1'b1;
            end else begin
                s_d.done = 1'b1;
                s_d.emit = line_conn;
                if (s_d.csr[IE_BIT])
                    s_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.done <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata  = reg_addr[1] ? {8'h00, s_q.chr} : view;
    assign char_valid = s_q.emit;
    assign char_data  = s_q.chr;
    assign irq        = s_q.irq;

    // R5
    emit_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> ($past(line_conn) && $past(tx_ready)));

    // R7
    emit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> reg_rdata_done_q);

    // R8
    irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (s_q.done && s_q.csr[IE_BIT]));

    // R4
    buf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> (!s_q.done && !irq));

    logic reg_rdata_done_q;
    assign reg_rdata_done_q = s_q.done;
endmodule

// File: tb/txc_line_tx_tb_top.sv
`timescale 1ns/1ps
module txc_line_tx_tb_top;
    localparam int D = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'b00;
    logic        reg_wr = 1'b0;
    logic        reg_byte = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        line_conn = 1'b0;
    logic        modem_en = 1'b0;
    logic        modem_cts = 1'b0;
    logic        tx_ready = 1'b0;
    logic        char_valid;
    logic [7:0]  char_data;
    logic        irq;

    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;
    int unsigned w_cyc = 0;
    logic [15:0] v;

    typedef struct {
        logic [7:0]  d;
        int unsigned c;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    txc_line_tx #(.DELAY_CYCLES(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_byte(reg_byte), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .line_conn(line_conn), .modem_en(modem_en), .modem_cts(modem_cts),
        .tx_ready(tx_ready), .char_valid(char_valid), .char_data(char_data),
        .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic b);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_byte = b; reg_wr = 1'b1;
        @(posedge clk);
        #1;
        w_cyc = cyc;
        reg_wr = 1'b0; reg_byte = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_until(input int unsigned n);
        do @(negedge clk); while (cyc < n);
    endtask

    task automatic push(input logic [7:0] d, input int unsigned c);
        exp_t e;
        e.d = d; e.c = c;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (rst_n && char_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 unexpected emit", {24'h0, char_data}, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(char_data == e.d, "R5 emitted data", {24'h0, char_data}, {24'h0, e.d});
                chk(cyc == e.c, "R5 emit cycle", cyc, e.c);
            end
        end
    end

    initial begin
        #(8 * 20000);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(2'b00, v); chk(v == 16'h0080, "R1 csr", v, 16'h0080);
        rd(2'b10, v); chk(v == 16'h0000, "R1 buffer", v, 16'h0000);
        chk(irq == 1'b0 && char_valid == 1'b0, "R1 irq/valid", {irq, char_valid}, 0);

        // R2 write mask, R8 ie raise/withdraw
        wr(2'b00, 16'hFFFF, 1'b0);
        rd(2'b00, v); chk(v == 16'h01DD, "R2 masked csr", v, 16'h01DD);
        chk(irq == 1'b1, "R8 ie set with done", irq, 1);
        wr(2'b00, 16'h0000, 1'b0);
        rd(2'b00, v); chk(v == 16'h0080, "R2 csr cleared", v, 16'h0080);
        chk(irq == 1'b0, "R8 ie cleared", irq, 0);

        // R3 byte lanes
        wr(2'b01, 16'h0001, 1'b1);
        rd(2'b00, v); chk(v == 16'h0180, "R3 odd byte", v, 16'h0180);
        wr(2'b00, 16'h0005, 1'b1);
        rd(2'b00, v); chk(v == 16'h0185, "R3 even byte", v, 16'h0185);
        wr(2'b00, 16'h0000, 1'b0);

        // R9 clear-to-send
        @(negedge clk) line_conn = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'b00, v); chk(v == 16'h0082, "R9 connect sets cts", v, 16'h0082);
        @(negedge clk) line_conn = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'b00, v); chk(v[1] == 1'b0, "R9 drop clears cts", v[1], 0);
        @(negedge clk) begin modem_en = 1'b1; modem_cts = 1'b1; end
        repeat (2) @(negedge clk);
        rd(2'b00, v); chk(v[1] == 1'b1, "R9 modem cts high", v[1], 1);
        @(negedge clk) modem_cts = 1'b0;
        repeat (2) @(negedge clk);
        rd(2'b00, v); chk(v[1] == 1'b0, "R9 modem cts low", v[1], 0);
        @(negedge clk) modem_en = 1'b0;

        // R5 connected and ready
        @(negedge clk) begin line_conn = 1'b1; tx_ready = 1'b1; end
        wr(2'b10, 16'h00A5, 1'b0);
        push(8'hA5, w_cyc + D);
        rd(2'b00, v); chk(v[7] == 1'b0, "R4 done cleared", v[7], 0);
        wait_until(w_cyc + D + 2);
        rd(2'b00, v); chk(v[7] == 1'b1, "R5 done after emit", v[7], 1);
        rd(2'b10, v); chk(v == 16'h00A5, "R10 buffer readback", v, 16'h00A5);

        // R6 not ready at first expiry
        @(negedge clk) tx_ready = 1'b0;
        wr(2'b10, 16'h003C, 1'b0);
        push(8'h3C, w_cyc + 2 * D);
        wait_until(w_cyc + D + 1);
        #1 chk(reg_rdata[7] == 1'b0 || reg_addr != 2'b00, "R6 no done on retry", reg_rdata[7], 0);
        rd(2'b00, v); chk(v[7] == 1'b0, "R6 done still low", v[7], 0);
        tx_ready = 1'b1;
        wait_until(w_cyc + 2 * D + 2);
        rd(2'b00, v); chk(v[7] == 1'b1, "R6 done after retry", v[7], 1);

        // R7 unconnected line
        @(negedge clk) line_conn = 1'b0;
        wr(2'b10, 16'h0077, 1'b0);
        wait_until(w_cyc + D - 1);
        reg_addr = 2'b00; #1;
        chk(reg_rdata[7] == 1'b0, "R7 done before delay", reg_rdata[7], 0);
        wait_until(w_cyc + D);
        #1 chk(reg_rdata[7] == 1'b1, "R7 done at delay", reg_rdata[7], 1);
        wait_until(w_cyc + D + 3);
        chk(sb.size() == 0, "R7 nothing emitted", sb.size(), 0);

        // R4 odd byte write starts without loading
        @(negedge clk) line_conn = 1'b1;
        wr(2'b11, 16'h0011, 1'b1);
        push(8'h77, w_cyc + D);
        rd(2'b10, v); chk(v == 16'h0077, "R4 odd byte no load", v, 16'h0077);
        wait_until(w_cyc + D + 2);

        // R8 interrupt on done
        wr(2'b00, 16'h0040, 1'b0);
        @(negedge clk) chk(irq == 1'b1, "R8 ie with done", irq, 1);
        wr(2'b10, 16'h0012, 1'b0);
        push(8'h12, w_cyc + D);
        @(negedge clk) chk(irq == 1'b0, "R4 irq withdrawn", irq, 0);
        wait_until(w_cyc + D + 1);
        chk(irq == 1'b1, "R8 irq on completion", irq, 1);

        wait_until(cyc + 4);
        chk(sb.size() == 0, "R5 all emitted", sb.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule